// File: doc/BRIEF.md
# Packed Signed Lane Adder with Sign Flags

This unit treats two 32-bit words as vectors of signed integers and adds them lane by lane. A one-bit mode input chooses the lane size: four byte lanes or two halfword lanes. Each lane's sum is truncated to the lane width, so a result that is too large wraps around. The unit also returns a four-bit flag vector that gives the true sign of every lane's sum. A flag is set when the lane sum is zero or positive.

The sign is taken from a sum one bit wider than the lane, so the flags stay correct when a result lane wraps. In halfword mode each lane's flag is copied into two adjacent flag bits. The full flag vector therefore always has four bits, whatever the lane size. Software can then use the flags to select bytes after either form of the add.

Operands are captured on a clock edge where the input strobe is high. The result, the flags and an output strobe appear one register stage later. While the strobe is low, the outputs keep their last values.

Top module: `psimd_add`

## Requirements
- R1: With mode_i = 0, byte lane i occupies bits [8i+7:8i] of each operand and of the result. Each result byte is the low 8 bits of the sum of the two sign-extended operand bytes.
- R2: With mode_i = 0, ge_o bit i is 1 exactly when the exact signed sum of byte lane i is greater than or equal to zero. Otherwise it is 0.
- R3: With mode_i = 1, halfword lane 0 is bits [15:0] and lane 1 is bits [31:16]. Each result halfword is the low 16 bits of the sign-extended sum.
- R4: With mode_i = 1, ge_o bits 2i and 2i+1 are both 1 when the exact sum of halfword lane i is nonnegative. Both are 0 when it is negative.
- R5: A lane that overflows or underflows wraps in the result, but its flag still follows the true sign. For example, 0x7F + 0x01 gives 0x80 with the flag set, and 0x80 + 0x80 gives 0x00 with the flag clear.
- R6: The mode encoding is 0 for four byte lanes and 1 for two halfword lanes. The same operand pair gives different results under the two modes.
- R7: Operands and mode are sampled on a rising clock edge where in_valid_i = 1. The result and flags appear after that edge, with out_valid_o = 1 for exactly the following cycle.
- R8: After an edge with in_valid_i = 0, out_valid_o is 0 and result_o and ge_o keep their previous values, even if the operands change.
- R9: A synchronous active-high reset (rst_i) clears out_valid_o, result_o and ge_o to zero.
- R10: Each accepted operation rewrites all four ge_o bits. No flag from an earlier operation survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operand strobe; high captures the operands |
| mode_i | input | 1 | Lane size: 0 = bytes, 1 = halfwords |
| op_a_i | input | 32 | First packed operand |
| op_b_i | input | 32 | Second packed operand |
| out_valid_o | output | 1 | High for the cycle after an accepted operation |
| result_o | output | 32 | Packed, wrapped lane sums |
| ge_o | output | 4 | Per-byte sign flags (1 = sum nonnegative) |

## Verification
The directed vectors include sums that land exactly on zero, such as 0xFF + 0x01 and 0x0000 + 0x0000. These show whether the flag uses "greater than or equal" rather than "greater than". Pairs that overflow in the positive and in the negative direction (0x7F + 0x7F, 0x80 + 0x80, 0x8000 + 0xFFFF) show whether the flag comes from the widened sum or from the wrapped result bit. The same operand pair is applied in both modes. This tells apart byte lanes, where carries stop at byte boundaries, and halfword lanes, where carries cross them. A flag-all-ones operation followed by a flag-all-zeros operation exposes stale flag bits. Several hundred random operand pairs in alternating modes are then compared against a reference model in the bench.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned NUM_BYTES  = DATA_W / BYTE_W;
    localparam int unsigned NUM_HALVES = DATA_W / HALF_W;
    localparam int unsigned HALF_SPAN  = HALF_W / BYTE_W;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_HALF = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic                  valid;
        lane_mode_e            mode;
        logic [DATA_W-1:0]     result;
        logic [NUM_BYTES-1:0]  ge;
    } stage_t;

endpackage

// File: rtl/psimd_lane_add.sv
module psimd_lane_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         nonneg_o
);

    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        sum_o    = wide_sum[W-1:0];
        nonneg_o = ~wide_sum[W];
    end

    // R5: the flag follows the operand signs, whatever happens to the wrapped lane
    always_comb begin
        if (!a_i[W-1] && !b_i[W-1]) begin
            assert_pos_pair_flag_R5: assert (nonneg_o)
                else $error("two nonnegative lanes gave a negative flag");
        end
        if (a_i[W-1] && b_i[W-1]) begin
            assert_neg_pair_flag_R5: assert (!nonneg_o)
                else $error("two negative lanes gave a nonnegative flag");
        end
    end

endmodule

// File: rtl/psimd_ge_spread.sv
module psimd_ge_spread
    import psimd_pkg::*;
(
    input  lane_mode_e             mode_i,
    input  logic [NUM_BYTES-1:0]   byte_nonneg_i,
    input  logic [NUM_HALVES-1:0]  half_nonneg_i,
    output logic [NUM_BYTES-1:0]   ge_o
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flag
        always_comb begin
            if (mode_i == MODE_HALF) begin
                ge_o[g] = half_nonneg_i[g / HALF_SPAN];
            end else begin
                ge_o[g] = byte_nonneg_i[g];
            end
        end
    end

endmodule

// File: rtl/psimd_add.sv
module psimd_add
    import psimd_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  in_valid_i,
    input  logic                  mode_i,
    input  logic [DATA_W-1:0]     op_a_i,
    input  logic [DATA_W-1:0]     op_b_i,
    output logic                  out_valid_o,
    output logic [DATA_W-1:0]     result_o,
    output logic [NUM_BYTES-1:0]  ge_o
);

    lane_mode_e              mode_sel;
    logic [DATA_W-1:0]       byte_sum;
    logic [DATA_W-1:0]       half_sum;
    logic [NUM_BYTES-1:0]    byte_nonneg;
    logic [NUM_HALVES-1:0]   half_nonneg;
    logic [NUM_BYTES-1:0]    ge_next;
    stage_t                  stage_d;
    stage_t                  stage_q;

    assign mode_sel = lane_mode_e'(mode_i);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        psimd_lane_add #(.W(BYTE_W)) u_lane (
            .a_i      (op_a_i[i*BYTE_W +: BYTE_W]),
            .b_i      (op_b_i[i*BYTE_W +: BYTE_W]),
            .sum_o    (byte_sum[i*BYTE_W +: BYTE_W]),
            .nonneg_o (byte_nonneg[i])
        );
    end

    for (genvar j = 0; j < NUM_HALVES; j++) begin : g_half
        psimd_lane_add #(.W(HALF_W)) u_lane (
            .a_i      (op_a_i[j*HALF_W +: HALF_W]),
            .b_i      (op_b_i[j*HALF_W +: HALF_W]),
            .sum_o    (half_sum[j*HALF_W +: HALF_W]),
            .nonneg_o (half_nonneg[j])
        );
    end

    psimd_ge_spread u_spread (
        .mode_i        (mode_sel),
        .byte_nonneg_i (byte_nonneg),
        .half_nonneg_i (half_nonneg),
        .ge_o          (ge_next)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid_i;
        if (in_valid_i) begin
            stage_d.mode   = mode_sel;
            stage_d.result = (mode_sel == MODE_HALF) ? half_sum : byte_sum;
            stage_d.ge     = ge_next;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid_o = stage_q.valid;
    assign result_o    = stage_q.result;
    assign ge_o        = stage_q.ge;

    // R7: an accepted operation is reported on the next cycle
    assert_valid_launch_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o);

    // R8: an idle cycle leaves the outputs untouched
    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(ge_o)));

    // R9: reset clears the output strobe
    assert_reset_clear_R9: assert property (@(posedge clk_i)
        rst_i |=> (!out_valid_o && result_o == '0 && ge_o == '0));

    // R4: in halfword mode, both flag bits of a lane agree
    for (genvar k = 0; k < NUM_HALVES; k++) begin : g_pair_chk
        assert_half_pair_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            (in_valid_i && mode_i == 1'b1) |=>
            (ge_o[k*HALF_SPAN] == ge_o[k*HALF_SPAN + HALF_SPAN - 1]));
    end

endmodule

// File: tb/psimd_add_bench.sv
module psimd_add_bench;

    typedef struct packed {
        logic        mode;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [3:0]  ge;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h807FFF00, 32'h807F0100, 32'h00FE0000, 4'b0111}, // R1 R2 R5 corners
        '{1'b0, 32'h7F10F0C0, 32'h0110F0C0, 32'h8020E080, 4'b1100}, // R5 wrap both ways
        '{1'b0, 32'h00FF00FF, 32'h00010001, 32'h00000000, 4'b1111}, // R6 byte view
        '{1'b0, 32'h01020304, 32'hFEFDFCFB, 32'hFFFFFFFF, 4'b0000}, // R10 all flags drop
        '{1'b1, 32'h00FF00FF, 32'h00010001, 32'h01000100, 4'b1111}, // R6 half view
        '{1'b1, 32'h80000000, 32'hFFFF0000, 32'h7FFF0000, 4'b0011}, // R4 R5 0x8000+0xFFFF
        '{1'b1, 32'h7FFF8000, 32'h7FFF8000, 32'hFFFE0000, 4'b1100}, // R3 R5
        '{1'b1, 32'h00010005, 32'hFFFFFFFA, 32'h0000FFFF, 4'b1100}, // R3 R4 zero sum
        '{1'b1, 32'h00000000, 32'h00000000, 32'h00000000, 4'b1111}, // R4 0+0
        '{1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 4'b1111}  // R2 0+0
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        mode;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  ge;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    psimd_add u_psimd_add (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .mode_i      (mode),
        .op_a_i      (op_a),
        .op_b_i      (op_b),
        .out_valid_o (out_valid),
        .result_o    (result),
        .ge_o        (ge)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void ref_add(input logic m, input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] r, output logic [3:0] g);
        int s;
        r = '0;
        g = '0;
        if (!m) begin
            for (int i = 0; i < 4; i++) begin
                s = $signed(a[8*i +: 8]) + $signed(b[8*i +: 8]);
                r[8*i +: 8] = s[7:0];
                g[i] = (s >= 0);
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                s = $signed(a[16*i +: 16]) + $signed(b[16*i +: 16]);
                r[16*i +: 16] = s[15:0];
                g[2*i]   = (s >= 0);
                g[2*i+1] = (s >= 0);
            end
        end
    endfunction

    // drive one operation at a falling edge, check it at the next falling edge
    task automatic apply(input string req, input logic m, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] er, input logic [3:0] eg);
        @(negedge clk);
        in_valid = 1'b1;
        mode     = m;
        op_a     = a;
        op_b     = b;
        @(negedge clk);
        check({req, " result"}, result, er);
        check({req, " ge"}, {28'd0, ge}, {28'd0, eg});
        check("R7 out_valid", {31'd0, out_valid}, 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] er;
        logic [3:0]  eg;
        logic [31:0] held_r;
        logic [3:0]  held_g;
        rst      = 1'b1;
        in_valid = 1'b1;
        mode     = 1'b0;
        op_a     = 32'h7F7F7F7F;
        op_b     = 32'h01010101;
        repeat (3) @(negedge clk);
        // R9: reset wins over a valid request
        check("R9 out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 result", result, 32'd0);
        check("R9 ge", {28'd0, ge}, 32'd0);
        in_valid = 1'b0;
        rst      = 1'b0;

        // R1 R2 R3 R4 R5 R6 R10: table walked back to back
        for (int v = 0; v < NVEC; v++) begin
            apply("R1-vec/R3-vec table", VECS[v].mode, VECS[v].a, VECS[v].b, VECS[v].res, VECS[v].ge);
        end

        // R8: idle cycle with changed operands leaves outputs alone
        held_r = result;
        held_g = ge;
        @(negedge clk);
        in_valid = 1'b0;
        mode     = 1'b1;
        op_a     = 32'hDEADBEEF;
        op_b     = 32'h12345678;
        @(negedge clk);
        check("R8 out_valid low", {31'd0, out_valid}, 32'd0);
        check("R8 result held", result, held_r);
        check("R8 ge held", {28'd0, ge}, {28'd0, held_g});
        @(negedge clk);
        check("R8 result still held", result, held_r);

        // R10: all-ones flags then all-zeros flags in halfword mode
        apply("R10 set", 1'b1, 32'h00010001, 32'h00010001, 32'h00020002, 4'b1111);
        apply("R10 clear", 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFEFFFE, 4'b0000);

        // R1 R2 R3 R4: random operands in alternating modes against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = $urandom;
            ref_add(n[0], ra, rb, er, eg);
            apply(n[0] ? "R3 R4 random" : "R1 R2 random", n[0], ra, rb, er, eg);
        end

        // R9: reset in mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        check("R9 mid-run out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 mid-run result", result, 32'd0);
        check("R9 mid-run ge", {28'd0, ge}, 32'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule